// File: doc/BRIEF.md
# Protected Address Translation Buffer

This block caches recent virtual-to-physical page translations for one pipeline access port. A 32-bit virtual address splits into a 20-bit virtual page number and a 12-bit page offset. All eight entries are compared against the page number in parallel. On a hit, the physical address, formed from the stored physical page number and the untouched offset, appears in the same cycle as the request. Each lookup also goes through a permission check. That check uses the privilege of the requester (kernel or user) and the kind of access (read or write).

When a lookup finds no entry, the block raises a miss. It then holds a walk request, carrying the missing page number, until a page table walker answers on the refill port. The walker either installs a translation with its permission bits, or reports that the page is not resident. In the second case the block raises a page-fault pulse and installs nothing. The pipeline sees three separate conditions: a miss, a protection fault and a page fault. A flush input drops every translation in one cycle when the address space changes.

Top module: `tlb_prot`

## Requirements
- R1: A lookup whose page number matches a valid entry and passes the permission check drives hit=1 and pa={entry physical page number, lk_va[11:0]} combinationally in the same cycle, with miss=0 and prot_fault=0.
- R2: A lookup with no matching valid entry drives miss=1, hit=0 and pa=0. If no walk is pending and no refill is presented that cycle, walk_req is 1 from the next cycle, with walk_vpn = lk_va[31:12]. It stays 1 until a refill is presented.
- R3: A refill (rf_valid=1, rf_fault=0, flush=0) installs its page number, physical page number and the bits r, w, kernel-only and dirty, and is visible to lookups from the next cycle. A refill whose page number is already present overwrites that entry and evicts nothing.
- R4: A new page is placed in the lowest-index invalid entry. When all entries are valid, it goes to the entry named by a round-robin pointer. The pointer starts at 0 after reset and advances by one (wrapping) only on such a replacement.
- R5: A user-mode lookup (lk_user=1) that hits a kernel-only entry drives prot_fault=1, hit=1, miss=0 and pa=0.
- R6: A write that hits an entry with w=0, or a read that hits an entry with r=0, drives prot_fault=1 and pa=0.
- R7: hit_dirty shows the dirty bit of the entry that hits. A permitted write hit sets that entry's dirty bit at the clock edge. A faulting write leaves it unchanged.
- R8: flush=1 clears every valid bit at the clock edge. A refill presented in the same cycle is not installed.
- R9: A refill with rf_fault=1 drives page_fault=1 for exactly the next cycle, installs no entry, and clears walk_req.
- R10: After reset no entry is valid, walk_req=0 and page_fault=0.
- R11: hit and miss are never 1 together, and prot_fault is 1 only together with hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address of the lookup |
| lk_write | input | 1 | 1 = write access, 0 = read |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| flush | input | 1 | Invalidate all entries |
| rf_valid | input | 1 | Walker response present |
| rf_fault | input | 1 | Walker found the page not resident |
| rf_vpn | input | 20 | Page number being refilled |
| rf_ppn | input | 20 | Physical page number for the refill |
| rf_r | input | 1 | Read permitted |
| rf_w | input | 1 | Write permitted |
| rf_k | input | 1 | Page is kernel-only |
| rf_d | input | 1 | Initial dirty bit |
| pa | output | 32 | Physical address, 0 unless a permitted hit |
| hit | output | 1 | Matching valid entry found |
| miss | output | 1 | No matching valid entry |
| prot_fault | output | 1 | Hit that fails the permission check |
| hit_dirty | output | 1 | Dirty bit of the hitting entry |
| walk_req | output | 1 | Walk pending |
| walk_vpn | output | 20 | Page number the walk is for |
| page_fault | output | 1 | One-cycle pulse: walker reported page not resident |

## Verification
The bench tries each permission rule on its own. One page is read-only, one is kernel-only, one is write-only, and each is accessed both ways, so a check that mixes the read and write bits, or ignores the privilege mode, passes an access it should block or blocks one it should pass. It fills all eight entries and then refills twice more. That shows whether replacement evicts in pointer order and prefers a free slot. It also overwrites a page that is already present, which a buggy design would duplicate or use to evict an unrelated page. Two more cases check that a flush beats a refill in the same cycle and that a not-resident response leaves no entry behind. A design that got these wrong would keep stale translations or report a miss as a page fault.

// File: rtl/tlb_prot.sv
module tlb_prot #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PPN_W   = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lk_valid,
  input  logic [VA_W-1:0]       lk_va,
  input  logic                  lk_write,
  input  logic                  lk_user,
  input  logic                  flush,
  input  logic                  rf_valid,
  input  logic                  rf_fault,
  input  logic [VA_W-OFF_W-1:0] rf_vpn,
  input  logic [PPN_W-1:0]      rf_ppn,
  input  logic                  rf_r,
  input  logic                  rf_w,
  input  logic                  rf_k,
  input  logic                  rf_d,
  output logic [PPN_W+OFF_W-1:0] pa,
  output logic                  hit,
  output logic                  miss,
  output logic                  prot_fault,
  output logic                  hit_dirty,
  output logic                  walk_req,
  output logic [VA_W-OFF_W-1:0] walk_vpn,
  output logic                  page_fault
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] ev, er, ew, ek, ed;
  logic [VPN_W-1:0]   etag [ENTRIES];
  logic [PPN_W-1:0]   eppn [ENTRIES];
  logic [IDX_W-1:0]   rr;

  wire [VPN_W-1:0] vpn = lk_va[VA_W-1:OFF_W];

  logic [ENTRIES-1:0] lk_m, rf_m;
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign lk_m[i] = ev[i] && (etag[i] == vpn);
    assign rf_m[i] = ev[i] && (etag[i] == rf_vpn);
  end

  logic [IDX_W-1:0] hidx, midx, fidx, vidx;
  always_comb begin
    hidx = '0;
    midx = '0;
    fidx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_m[i]) hidx = IDX_W'(i);
      if (rf_m[i]) midx = IDX_W'(i);
    end
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!ev[i]) fidx = IDX_W'(i);
  end

  wire rf_present = |rf_m;
  wire all_valid  = &ev;
  assign vidx = rf_present ? midx : (all_valid ? rr : fidx);

  wire any_m = |lk_m;
  wire viol  = (lk_user && ek[hidx]) || (lk_write ? !ew[hidx] : !er[hidx]);

  assign hit        = lk_valid && any_m;
  assign miss       = lk_valid && !any_m;
  assign prot_fault = hit && viol;
  assign hit_dirty  = hit && ed[hidx];
  assign pa         = (hit && !viol) ? {eppn[hidx], lk_va[OFF_W-1:0]} : '0;

  wire install = rf_valid && !rf_fault && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev <= '0; er <= '0; ew <= '0; ek <= '0; ed <= '0;
      rr <= '0;
    end else if (flush) begin
      ev <= '0;
    end else begin
      if (hit && lk_write && !viol) ed[hidx] <= 1'b1;
      if (install) begin
        ev[vidx] <= 1'b1;
        er[vidx] <= rf_r;
        ew[vidx] <= rf_w;
        ek[vidx] <= rf_k;
        ed[vidx] <= rf_d;
        if (!rf_present && all_valid)
          rr <= (rr == IDX_W'(ENTRIES - 1)) ? '0 : rr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (install) begin
      etag[vidx] <= rf_vpn;
      eppn[vidx] <= rf_ppn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      walk_req   <= 1'b0;
      walk_vpn   <= '0;
      page_fault <= 1'b0;
    end else begin
      page_fault <= rf_valid && rf_fault;
      if (rf_valid) walk_req <= 1'b0;
      else if (miss && !walk_req) begin
        walk_req <= 1'b1;
        walk_vpn <= vpn;
      end
    end
  end

  assert_hit_miss_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && miss));
  assert_fault_on_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prot_fault |-> (hit && pa == '0));
  assert_walk_raise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && !rf_valid) |=> walk_req);
  assert_refill_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && $past(install) && vpn == $past(rf_vpn)) |-> hit);
  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> !hit);
  assert_pf_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    page_fault |-> $past(rf_valid && rf_fault));
  assert_dirty_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hit && lk_write && !prot_fault && !rf_valid && !flush) &&
     hit && vpn == $past(vpn)) |-> hit_dirty);
endmodule

// File: tb/tlb_prot_bench.sv
module tlb_prot_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 0, lk_write = 0, lk_user = 0, flush = 0;
  logic [31:0] lk_va = '0;
  logic rf_valid = 0, rf_fault = 0, rf_r = 0, rf_w = 0, rf_k = 0, rf_d = 0;
  logic [19:0] rf_vpn = '0, rf_ppn = '0;
  logic [31:0] pa;
  logic hit, miss, prot_fault, hit_dirty, walk_req, page_fault;
  logic [19:0] walk_vpn;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  tlb_prot u_tlb_prot (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va),
    .lk_write(lk_write), .lk_user(lk_user), .flush(flush),
    .rf_valid(rf_valid), .rf_fault(rf_fault), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn),
    .rf_r(rf_r), .rf_w(rf_w), .rf_k(rf_k), .rf_d(rf_d),
    .pa(pa), .hit(hit), .miss(miss), .prot_fault(prot_fault),
    .hit_dirty(hit_dirty), .walk_req(walk_req), .walk_vpn(walk_vpn),
    .page_fault(page_fault)
  );

  typedef struct packed {
    logic [19:0] vpn;
    logic [11:0] off;
    logic        wr;
    logic        usr;
    logic        e_hit;
    logic        e_miss;
    logic        e_flt;
    logic [19:0] e_ppn;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{20'h00010, 12'h123, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 20'hAAAAA, 4'd1}, // R1 read user rw page
    '{20'h00010, 12'hFFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 20'hAAAAA, 4'd1}, // R1 write user rw page
    '{20'h00020, 12'h000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 20'hBBBBB, 4'd1}, // R1 read-only page read
    '{20'h00020, 12'h004, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 20'h00000, 4'd6}, // R6 write to read-only
    '{20'h00030, 12'h800, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 20'h00000, 4'd5}, // R5 user on kernel page
    '{20'h00030, 12'h801, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 20'hCCCCC, 4'd1}, // R1 kernel read
    '{20'h00030, 12'h802, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 20'hCCCCC, 4'd1}, // R1 kernel write
    '{20'h00040, 12'h0A0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 20'h00000, 4'd6}, // R6 read to write-only
    '{20'h00040, 12'h0A4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 20'hDDDDD, 4'd1}, // R1 write-only write
    '{20'h00050, 12'h010, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 20'h00000, 4'd2}  // R2 miss
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [19:0] vpn, input logic [11:0] off,
                        input logic wr, input logic usr);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_va = {vpn, off};
    lk_write = wr;
    lk_user = usr;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    lk_valid = 1'b0;
    #1;
  endtask

  task automatic refill(input logic [19:0] vpn, input logic [19:0] ppn,
                        input logic r, input logic w, input logic k, input logic flt);
    @(negedge clk);
    lk_valid = 1'b0;
    rf_valid = 1'b1; rf_fault = flt; rf_vpn = vpn; rf_ppn = ppn;
    rf_r = r; rf_w = w; rf_k = k; rf_d = 1'b0;
    @(negedge clk);
    rf_valid = 1'b0; rf_fault = 1'b0;
    #1;
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    check("R10 walk_req", {31'd0, walk_req}, 32'd0);
    check("R10 page_fault", {31'd0, page_fault}, 32'd0);
    lookup(20'h00010, 12'h0, 1'b0, 1'b0);
    check("R10 empty miss", {29'd0, hit, miss, prot_fault}, 32'b010);

    refill(20'h00010, 20'hAAAAA, 1'b1, 1'b1, 1'b0, 1'b0);
    refill(20'h00020, 20'hBBBBB, 1'b1, 1'b0, 1'b0, 1'b0);
    refill(20'h00030, 20'hCCCCC, 1'b1, 1'b1, 1'b1, 1'b0);
    refill(20'h00040, 20'hDDDDD, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R2 walk cleared by refill", {31'd0, walk_req}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      string tg;
      tg = $sformatf("R%0d vec%0d", VEC[i].req, i);
      lookup(VEC[i].vpn, VEC[i].off, VEC[i].wr, VEC[i].usr);
      // R11 flags checked jointly
      check({tg, " flags"}, {29'd0, hit, miss, prot_fault},
            {29'd0, VEC[i].e_hit, VEC[i].e_miss, VEC[i].e_flt});
      check({tg, " pa"}, pa,
            (VEC[i].e_hit && !VEC[i].e_flt) ? {VEC[i].e_ppn, VEC[i].off} : 32'd0);
    end

    idle();
    check("R2 walk_req", {31'd0, walk_req}, 32'd1);
    check("R2 walk_vpn", {12'd0, walk_vpn}, 32'h00050);

    // R7 dirty tracking
    lookup(20'h00010, 12'h0, 1'b0, 1'b1);
    check("R7 dirty after write", {31'd0, hit_dirty}, 32'd1);
    lookup(20'h00020, 12'h0, 1'b0, 1'b1);
    check("R7 faulting write leaves clean", {31'd0, hit_dirty}, 32'd0);
    lookup(20'h00030, 12'h0, 1'b0, 1'b0);
    check("R7 kernel write dirty", {31'd0, hit_dirty}, 32'd1);

    refill(20'h00050, 20'h55555, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R2 walk_req cleared", {31'd0, walk_req}, 32'd0);
    lookup(20'h00050, 12'h321, 1'b0, 1'b1);
    check("R3 refilled pa", pa, 32'h55555321);

    // R9 not-resident response
    lookup(20'h00060, 12'h0, 1'b0, 1'b1);
    check("R9 miss first", {31'd0, miss}, 32'd1);
    idle();
    check("R2 walk_vpn second", {12'd0, walk_vpn}, 32'h00060);
    refill(20'h00060, 20'h66666, 1'b1, 1'b1, 1'b0, 1'b1);
    check("R9 page_fault pulse", {31'd0, page_fault}, 32'd1);
    check("R9 walk_req cleared", {31'd0, walk_req}, 32'd0);
    lookup(20'h00060, 12'h0, 1'b0, 1'b1);
    check("R9 nothing installed", {30'd0, hit, miss}, 32'b01);
    check("R9 pulse one cycle", {31'd0, page_fault}, 32'd0);

    // R4 fill, then round-robin replacement
    refill(20'h00070, 20'h70000, 1'b1, 1'b1, 1'b0, 1'b0);
    refill(20'h00071, 20'h71000, 1'b1, 1'b1, 1'b0, 1'b0);
    refill(20'h00072, 20'h72000, 1'b1, 1'b1, 1'b0, 1'b0);
    lookup(20'h00010, 12'h0, 1'b0, 1'b0);
    check("R4 full set keeps first", {31'd0, hit}, 32'd1);
    refill(20'h00080, 20'h80000, 1'b1, 1'b1, 1'b0, 1'b0);
    lookup(20'h00010, 12'h0, 1'b0, 1'b0);
    check("R4 entry0 evicted", {31'd0, miss}, 32'd1);
    lookup(20'h00020, 12'h0, 1'b0, 1'b0);
    check("R4 entry1 kept", {31'd0, hit}, 32'd1);
    refill(20'h00081, 20'h81000, 1'b1, 1'b1, 1'b0, 1'b0);
    lookup(20'h00020, 12'h0, 1'b0, 1'b0);
    check("R4 entry1 evicted", {31'd0, miss}, 32'd1);
    lookup(20'h00030, 12'h0, 1'b0, 1'b0);
    check("R4 entry2 kept", {31'd0, hit}, 32'd1);

    // R3 overwrite of a present page evicts nothing
    refill(20'h00080, 20'h12345, 1'b1, 1'b1, 1'b0, 1'b0);
    lookup(20'h00080, 12'hABC, 1'b0, 1'b1);
    check("R3 overwrite pa", pa, 32'h12345ABC);
    lookup(20'h00030, 12'h0, 1'b0, 1'b0);
    check("R3 no eviction on overwrite", {31'd0, hit}, 32'd1);

    // R8 flush beats a same-cycle refill
    @(negedge clk);
    lk_valid = 1'b0;
    flush = 1'b1;
    rf_valid = 1'b1; rf_fault = 1'b0; rf_vpn = 20'h00090; rf_ppn = 20'h90000;
    rf_r = 1'b1; rf_w = 1'b1; rf_k = 1'b0;
    @(negedge clk);
    flush = 1'b0; rf_valid = 1'b0;
    lookup(20'h00030, 12'h0, 1'b0, 1'b0);
    check("R8 flushed entry misses", {30'd0, hit, miss}, 32'b01);
    lookup(20'h00090, 12'h0, 1'b0, 1'b0);
    check("R8 refill dropped", {30'd0, hit, miss}, 32'b01);
    idle();

    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end
endmodule